// File: doc/BRIEF.md
# Speaker Control and System Status Port

This block is an 8-bit legacy I/O register that sits at one decoded address on a simple I/O bus. Software writes it to start or stop timer channel 2 and to connect that timer's square wave to the speaker pin. The same port also reports system status. The status bits are the live timer 2 output, a sticky flag that records an expansion-bus channel-check error, and an indicator that flips once for every memory-refresh request.

A channel-check error sets the sticky flag and raises the non-maskable interrupt request. The flag stays set until software writes the disable/clear control bit. While that control bit is 1, the flag is held clear and new errors are not recorded. The asynchronous channel-check and refresh inputs each pass through a flop synchroniser before the block uses them. The timer output is read back directly, with no synchronisation. Global NMI masking and the timer itself are outside this block.

Top module: `spkr_status_port`

## Requirements
- R1: After reset, the control bits 3..0, the error flag and the refresh indicator are 0. A read with timer input 0 returns 8'h00, and gate, speaker and NMI request are all 0.
- R2: A write with io_wr=1 and io_addr equal to PORT_ADDR loads write-data bits 3..0 into control bits 3..0 at that clock edge. Write-data bits 7..4 are ignored.
- R3: A write or read at any other address has no effect on the register, and io_rdata is 8'h00 whenever the port is not being read.
- R4: tmr2_gate equals control bit 0.
- R5: spkr_out is the timer 2 input ANDed with control bit 1. When bit 1 is 0, spkr_out stays 0 whatever the timer does.
- R6: Read-data bit 5 follows tmr2_out combinationally, in the same cycle.
- R7: If chk_n is low at a clock edge while control bit 3 is 0, then read bit 6 and nmi_req become 1 after the third rising edge counted from that edge (SYNC_STAGES=2). Both stay 1 after chk_n returns high.
- R8: While control bit 3 is 1, read bit 6 and nmi_req are 0 and channel-check events are not recorded. After bit 3 is written back to 0, a new event is recorded again.
- R9: Read bit 4 inverts once for each low-to-high transition of rfsh_n, after synchronisation. A high-to-low transition leaves it unchanged.
- R10: Read bit 7 is always 0. Bit 2 is a plain read/write bit with no other effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0 when not addressed |
| tmr2_out | input | 1 | Timer channel 2 output |
| chk_n | input | 1 | Channel-check error, active low, asynchronous |
| rfsh_n | input | 1 | Refresh request, active low, asynchronous |
| tmr2_gate | output | 1 | Timer channel 2 gate |
| spkr_out | output | 1 | Speaker drive |
| nmi_req | output | 1 | Non-maskable interrupt request |

## Verification
The assertions assume that the bus strobes and write data are stable around the clock edge. They also assume that chk_n and rfsh_n may change at any time, because the synchroniser absorbs that. The bench drives every input on the falling clock edge, which keeps these assumptions true. It holds each channel-check and refresh level for at least two cycles and then waits several cycles before it reads. The synchroniser latency therefore always lies inside the checked window.

// File: rtl/spkr_port_pkg.sv
package spkr_port_pkg;
   // read-back positions; software decodes these
   localparam int POS_TGATE  = 0;
   localparam int POS_SPKEN  = 1;
   localparam int POS_SPARE  = 2;
   localparam int POS_CHKDIS = 3;
   localparam int POS_RFTOG  = 4;
   localparam int POS_TMR    = 5;
   localparam int POS_CHKFLG = 6;
   localparam int POS_ZERO   = 7;
   localparam int CTRL_W     = 4;

   typedef struct packed {
      logic chk_dis;
      logic spare;
      logic spk_en;
      logic tgate;
   } ctrl_t;
endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
   parameter int   STAGES  = 2,
   parameter logic RST_LVL = 1'b0,
   parameter bit   RISE    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic lvl,
   output logic edge_p
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= {STAGES{RST_LVL}};
         prev_q <= RST_LVL;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], d_async};
         prev_q <= sh_q[STAGES-1];
      end
   end

   assign lvl = sh_q[STAGES-1];

   if (RISE) begin : g_rise
      assign edge_p = lvl & ~prev_q;
   end else begin : g_fall
      assign edge_p = ~lvl & prev_q;
   end

   // R9
   edge_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_p |=> !edge_p);
endmodule

// File: rtl/ctrl_reg.sv
module ctrl_reg #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wd,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("ctrl_reg: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (we) q <= wd;
   end

   // R2
   ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> q == $past(wd));
   // R3
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));
endmodule

// File: rtl/chk_latch.sv
module chk_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic act,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (clr) flag <= 1'b0;
      else if (act) flag <= 1'b1;
   end

   // R7
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
   // R8
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !flag);
endmodule

// File: rtl/spkr_status_port.sv
module spkr_status_port
   import spkr_port_pkg::*;
#(
   parameter int              ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0061,
   parameter int              SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   input  logic              tmr2_out,
   input  logic              chk_n,
   input  logic              rfsh_n,
   output logic              tmr2_gate,
   output logic              spkr_out,
   output logic              nmi_req
);
   if (ADDR_W < 8) begin : g_bad_addr
      $error("spkr_status_port: ADDR_W must be at least 8");
   end

   logic  hit, wr_hit, rd_hit;
   logic [CTRL_W-1:0] ctrl_q;
   ctrl_t ctrl;
   logic  chk_lvl, chk_edge_unused;
   logic  rf_lvl_unused, rf_rise;
   logic  chk_flag;
   logic  rf_tog_q;

   assign hit    = (io_addr == PORT_ADDR);
   assign wr_hit = io_wr & hit;
   assign rd_hit = io_rd & hit;

   ctrl_reg #(.W(CTRL_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .we(wr_hit),
      .wd(io_wdata[CTRL_W-1:0]), .q(ctrl_q)
   );
   assign ctrl = ctrl_t'(ctrl_q);

   sync_edge #(.STAGES(SYNC_STAGES), .RST_LVL(1'b0), .RISE(1'b1)) chk_sync_i (
      .clk(clk), .rst_n(rst_n), .d_async(~chk_n),
      .lvl(chk_lvl), .edge_p(chk_edge_unused)
   );

   sync_edge #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1), .RISE(1'b1)) rf_sync_i (
      .clk(clk), .rst_n(rst_n), .d_async(rfsh_n),
      .lvl(rf_lvl_unused), .edge_p(rf_rise)
   );

   chk_latch chk_i (
      .clk(clk), .rst_n(rst_n), .act(chk_lvl),
      .clr(ctrl.chk_dis), .flag(chk_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rf_tog_q <= 1'b0;
      else if (rf_rise) rf_tog_q <= ~rf_tog_q;
   end

   assign tmr2_gate = ctrl.tgate;
   assign spkr_out  = tmr2_out & ctrl.spk_en;
   assign nmi_req   = chk_flag;

   always_comb begin
      io_rdata = 8'h00;
      if (rd_hit) begin
         io_rdata[POS_TGATE]  = ctrl.tgate;
         io_rdata[POS_SPKEN]  = ctrl.spk_en;
         io_rdata[POS_SPARE]  = ctrl.spare;
         io_rdata[POS_CHKDIS] = ctrl.chk_dis;
         io_rdata[POS_RFTOG]  = rf_tog_q;
         io_rdata[POS_TMR]    = tmr2_out;
         io_rdata[POS_CHKFLG] = chk_flag;
         io_rdata[POS_ZERO]   = 1'b0;
      end
   end

   // R9
   rf_tog_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rf_rise |=> $stable(rf_tog_q));
   // R7
   nmi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nmi_req) |-> $past(chk_lvl) && !$past(ctrl.chk_dis));
   // R5
   spkr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spkr_out |-> tmr2_out);
   // R4
   gate_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> tmr2_gate == $past(io_wdata[POS_TGATE]));
   // R8
   nmi_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.chk_dis |=> !nmi_req);
endmodule

// File: tb/spkr_status_port_tb_top.sv
module spkr_status_port_tb_top;
   typedef struct {
      logic [7:0] rdata;
      logic       gate;
      logic       spkr;
      logic       nmi;
      string      tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = 16'h0;
   logic        io_wr = 1'b0, io_rd = 1'b0;
   logic [7:0]  io_wdata = 8'h0;
   logic [7:0]  io_rdata;
   logic        tmr2_out = 1'b0, chk_n = 1'b1, rfsh_n = 1'b1;
   logic        tmr2_gate, spkr_out, nmi_req;

   int checks = 0, errors = 0;
   exp_t q[$];
   bit done = 1'b0;

   always #10 clk = ~clk;

   spkr_status_port dut_i (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
      .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .tmr2_out(tmr2_out), .chk_n(chk_n), .rfsh_n(rfsh_n),
      .tmr2_gate(tmr2_gate), .spkr_out(spkr_out), .nmi_req(nmi_req)
   );

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [7:0] er,
                     input logic eg, input logic es, input logic en,
                     input string tag);
      exp_t e;
      @(negedge clk);
      e.rdata = er; e.gate = eg; e.spkr = es; e.nmi = en; e.tag = tag;
      q.push_back(e);
      io_addr = a; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   // monitor: compares in mid high phase, away from both edges
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (io_rd) begin
            exp_t e;
            checks++;
            if (q.size() == 0) begin
               errors++;
               $display("FAIL monitor: read with empty queue, actual %h expected none", io_rdata);
            end else begin
               e = q.pop_front();
               if (io_rdata !== e.rdata || tmr2_gate !== e.gate ||
                   spkr_out !== e.spkr || nmi_req !== e.nmi) begin
                  errors++;
                  $display("FAIL %s: actual rdata=%h gate=%b spkr=%b nmi=%b expected rdata=%h gate=%b spkr=%b nmi=%b",
                           e.tag, io_rdata, tmr2_gate, spkr_out, nmi_req,
                           e.rdata, e.gate, e.spkr, e.nmi);
               end
            end
         end
      end
   end

   initial begin
      for (int c = 0; c < 20000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      rd(16'h0061, 8'h00, 0, 0, 0, "R1 reset state");
      // R2 upper bits ignored, R10 bit 2 read/write, bit 7 zero
      wr(16'h0061, 8'hF5);
      rd(16'h0061, 8'h05, 1, 0, 0, "R2 R10 write F5");
      // R3 other address
      wr(16'h0062, 8'h00);
      rd(16'h0061, 8'h05, 1, 0, 0, "R3 foreign write ignored");
      rd(16'h0060, 8'h00, 1, 0, 0, "R3 foreign read zero");
      // R6 timer visible, R5 speaker disabled
      @(negedge clk); tmr2_out = 1'b1;
      rd(16'h0061, 8'h25, 1, 0, 0, "R6 R5 timer high spk off");
      wr(16'h0061, 8'h03);
      rd(16'h0061, 8'h23, 1, 1, 0, "R5 R4 speaker on");
      @(negedge clk); tmr2_out = 1'b0;
      rd(16'h0061, 8'h03, 1, 0, 0, "R5 R6 timer low");
      wr(16'h0061, 8'h02);
      rd(16'h0061, 8'h02, 0, 0, 0, "R4 gate off");
      // R7 channel check sticky
      @(negedge clk); chk_n = 1'b0;
      idle(2); chk_n = 1'b1;
      idle(4);
      rd(16'h0061, 8'h42, 0, 0, 1, "R7 flag set");
      idle(3);
      rd(16'h0061, 8'h42, 0, 0, 1, "R7 flag sticky");
      // R8 clear and block
      wr(16'h0061, 8'h0A);
      rd(16'h0061, 8'h0A, 0, 0, 0, "R8 cleared");
      @(negedge clk); chk_n = 1'b0;
      idle(3); chk_n = 1'b1;
      idle(4);
      rd(16'h0061, 8'h0A, 0, 0, 0, "R8 blocked while disabled");
      wr(16'h0061, 8'h02);
      idle(2);
      rd(16'h0061, 8'h02, 0, 0, 0, "R8 no stale event");
      @(negedge clk); chk_n = 1'b0;
      idle(2); chk_n = 1'b1;
      idle(4);
      rd(16'h0061, 8'h42, 0, 0, 1, "R8 rearmed");
      wr(16'h0061, 8'h08);
      wr(16'h0061, 8'h00);
      // R9 refresh toggle
      @(negedge clk); rfsh_n = 1'b0;
      idle(5);
      rd(16'h0061, 8'h00, 0, 0, 0, "R9 falling edge no toggle");
      rfsh_n = 1'b1;
      idle(5);
      rd(16'h0061, 8'h10, 0, 0, 0, "R9 toggle on rise");
      @(negedge clk); rfsh_n = 1'b0;
      idle(2); rfsh_n = 1'b1;
      idle(5);
      rd(16'h0061, 8'h00, 0, 0, 0, "R9 second toggle");
      idle(3);
      if (q.size() != 0) begin
         checks++; errors++;
         $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule